// File: doc/BRIEF.md
# Ordered load/store request queue with conflict-checked load bypass

This block sits between one processor and a shared-memory interconnect. Every load and store the processor hands over goes into one common queue. The queue then offers exactly one request at a time on a ready/valid issue port.

A mode input picks the issue order. In the in-order setting the oldest entry always goes first. In the bypass setting a load may leave ahead of older stores, but only when none of those stores names the same word address. This means two requests to one word never change their relative order.

A second mode input controls the pacing. In the paced setting, after each issued request the block waits for a single untagged acknowledgement that the request has been performed. In the streaming setting it issues on every cycle the interconnect accepts.

Top module: `ldst_order_queue`

## Requirements
- R1: After reset the queue reports empty high, full low, issue valid low and enqueue ready high.
- R2: With bypass_en low, requests leave in exactly the order they were accepted, loads and stores alike.
- R3: With bypass_en high, a load whose address differs from every older queued store issues before those stores.
- R4: A load is never issued ahead of an older queued store whose word address is equal (is_store = 1 marks a store, 0 a load), and stores never overtake any older entry.
- R5: With bypass_en high, the oldest eligible load is chosen, and a store issues only when no queued load is eligible.
- R6: Once DEPTH entries are held, full is high and enq_ready is low, and an enqueue offered then is dropped: it never appears on the issue port.
- R7: With wait_ack high, after a request is accepted iss_valid stays low until ack is seen, and it rises in the cycle after the ack.
- R8: With wait_ack low, queued requests issue on consecutive cycles while iss_ready is high, with no ack.
- R9: While iss_valid is high and iss_ready low in in-order mode, the offered address, kind and data stay unchanged, even when new requests are enqueued.
- R10: An ack that arrives while no request is outstanding has no effect: it does not pre-release the next request in paced mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | 1: loads may pass non-conflicting older stores; 0: strict age order |
| wait_ack | input | 1 | 1: one request outstanding until ack; 0: issue at full rate |
| enq_valid | input | 1 | Processor offers a request |
| enq_ready | output | 1 | Queue can accept a request |
| enq_is_store | input | 1 | 1 store, 0 load |
| enq_addr | input | AW | Word address |
| enq_data | input | DW | Store data (carried for loads too) |
| iss_valid | output | 1 | A request is offered to the interconnect |
| iss_ready | input | 1 | Interconnect takes the offered request |
| iss_is_store | output | 1 | Kind of the offered request |
| iss_addr | output | AW | Address of the offered request |
| iss_data | output | DW | Data of the offered request |
| ack | input | 1 | Outstanding request has been performed |
| full | output | 1 | All DEPTH entries in use |
| empty | output | 1 | No entry in use |

## Verification
The bench builds the queue with DEPTH = 4 and 8-bit addresses and data. With that size, filling the queue and refusing a further enqueue takes only a few cycles. The small address space also makes it easy to set up matching and differing store/load addresses. Mixed store/load sequences are run in both order modes and in both pacing modes, and each issued kind, address and data value is compared with an order worked out from the rules.

// File: rtl/ldst_order_queue.sv
`timescale 1ns/1ps
module ldst_order_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_en,
  input  logic          wait_ack,
  input  logic          enq_valid,
  output logic          enq_ready,
  input  logic          enq_is_store,
  input  logic [AW-1:0] enq_addr,
  input  logic [DW-1:0] enq_data,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic          iss_is_store,
  output logic [AW-1:0] iss_addr,
  output logic [DW-1:0] iss_data,
  input  logic          ack,
  output logic          full,
  output logic          empty
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic          q_st   [DEPTH];
  logic [AW-1:0] q_addr [DEPTH];
  logic [DW-1:0] q_data [DEPTH];
  logic          n_st   [DEPTH];
  logic [AW-1:0] n_addr [DEPTH];
  logic [DW-1:0] n_data [DEPTH];
  logic [CW-1:0] count;
  logic          pending;
  logic [DEPTH-1:0] elig;
  logic [IW-1:0] sel;
  logic          pop, push;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign enq_ready = !full;
  assign iss_valid = !empty && !(wait_ack && pending);
  assign pop       = iss_valid && iss_ready;
  assign push      = enq_valid && enq_ready;

  assign iss_is_store = q_st[sel];
  assign iss_addr     = q_addr[sel];
  assign iss_data     = q_data[sel];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      elig[i] = (i < int'(count)) && !q_st[i];
      for (int j = 0; j < DEPTH; j++)
        if (j < i && q_st[j] && q_addr[j] == q_addr[i]) elig[i] = 1'b0;
    end
  end

  always_comb begin
    logic found;
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (bypass_en && elig[i] && !found) begin
        sel   = IW'(i);
        found = 1'b1;
      end
  end

  always_comb begin
    int wp;
    for (int i = 0; i < DEPTH; i++) begin
      n_st[i]   = q_st[i];
      n_addr[i] = q_addr[i];
      n_data[i] = q_data[i];
    end
    if (pop)
      for (int i = 0; i < DEPTH - 1; i++)
        if (i >= int'(sel)) begin
          n_st[i]   = q_st[i+1];
          n_addr[i] = q_addr[i+1];
          n_data[i] = q_data[i+1];
        end
    wp = int'(count) - (pop ? 1 : 0);
    if (push && wp >= 0 && wp < DEPTH) begin
      n_st[IW'(wp)]   = enq_is_store;
      n_addr[IW'(wp)] = enq_addr;
      n_data[IW'(wp)] = enq_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      pending <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        q_st[i]   <= 1'b0;
        q_addr[i] <= '0;
        q_data[i] <= '0;
      end
    end else begin
      count <= count + CW'(push) - CW'(pop);
      for (int i = 0; i < DEPTH; i++) begin
        q_st[i]   <= n_st[i];
        q_addr[i] <= n_addr[i];
        q_data[i] <= n_data[i];
      end
      if (!wait_ack)  pending <= 1'b0;
      else if (pop)   pending <= 1'b1;
      else if (ack)   pending <= 1'b0;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full && !enq_ready);

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ack && pop && !$past(!rst_n) |=> !iss_valid || !wait_ack);

  p_hold_offer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready && !bypass_en |=>
      bypass_en || ($stable(iss_addr) && $stable(iss_is_store) && $stable(iss_data)));

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !iss_valid);

  p_store_from_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_is_store |-> iss_addr == q_addr[0] && q_st[0]);
endmodule

// File: tb/sim_ldst_order_queue.sv
`timescale 1ns/1ps
module sim_ldst_order_queue;
  localparam int DEPTH = 4, AW = 8, DW = 8;
  logic clk = 0, rst_n = 0;
  logic bypass_en = 0, wait_ack = 0, enq_valid = 0, enq_is_store = 0;
  logic [AW-1:0] enq_addr = '0;
  logic [DW-1:0] enq_data = '0;
  logic iss_ready = 0, ack = 0;
  logic enq_ready, iss_valid, iss_is_store, full, empty;
  logic [AW-1:0] iss_addr;
  logic [DW-1:0] iss_data;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  ldst_order_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u0 (
    .clk, .rst_n, .bypass_en, .wait_ack, .enq_valid, .enq_ready, .enq_is_store,
    .enq_addr, .enq_data, .iss_valid, .iss_ready, .iss_is_store, .iss_addr,
    .iss_data, .ack, .full, .empty);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic enq(bit st, logic [AW-1:0] a, bit exp_rdy, string req);
    enq_valid = 1; enq_is_store = st; enq_addr = a; enq_data = a ^ 8'h5A;
    #0 check({req, " enq_ready"}, int'(enq_ready), int'(exp_rdy));
    step();
    enq_valid = 0;
  endtask

  task automatic pop_expect(bit st, logic [AW-1:0] a, string req);
    iss_ready = 1;
    #0;
    check({req, " iss_valid"}, int'(iss_valid), 1);
    check({req, " kind"}, int'(iss_is_store), int'(st));
    check({req, " addr"}, int'(iss_addr), int'(a));
    check({req, " data"}, int'(iss_data), int'(a ^ 8'h5A));
    step();
    iss_ready = 0;
  endtask

  task automatic t_reset();
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 iss_valid", int'(iss_valid), 0);
    check("R1 enq_ready", int'(enq_ready), 1);
  endtask

  task automatic t_strict();
    bypass_en = 0; wait_ack = 0;
    enq(1, 8'h10, 1, "R2"); enq(0, 8'h20, 1, "R2");
    enq(1, 8'h30, 1, "R2"); enq(0, 8'h40, 1, "R2");
    pop_expect(1, 8'h10, "R2"); pop_expect(0, 8'h20, "R2");
    pop_expect(1, 8'h30, "R2"); pop_expect(0, 8'h40, "R2");
    check("R2 empty after drain", int'(empty), 1);
  endtask

  task automatic t_bypass();
    bypass_en = 1; wait_ack = 0;
    enq(1, 8'h0A, 1, "R3"); enq(0, 8'h14, 1, "R3");
    enq(0, 8'h0A, 1, "R4"); enq(1, 8'h1E, 1, "R4");
    pop_expect(0, 8'h14, "R3 load passes store");
    pop_expect(1, 8'h0A, "R4 conflicting store first");
    pop_expect(0, 8'h0A, "R4 same-word load after store");
    pop_expect(1, 8'h1E, "R4 younger store last");
  endtask

  task automatic t_oldest_load();
    bypass_en = 1; wait_ack = 0;
    enq(1, 8'h05, 1, "R5"); enq(0, 8'h06, 1, "R5"); enq(0, 8'h07, 1, "R5");
    pop_expect(0, 8'h06, "R5 oldest eligible load");
    pop_expect(0, 8'h07, "R5 next load");
    pop_expect(1, 8'h05, "R5 store when no load eligible");
  endtask

  task automatic t_full();
    bypass_en = 0; wait_ack = 0;
    for (int i = 0; i < DEPTH; i++) enq(i[0], 8'(8'h60 + i), 1, "R6");
    check("R6 full", int'(full), 1);
    check("R6 enq_ready low", int'(enq_ready), 0);
    enq(0, 8'h77, 0, "R6 refused");
    for (int i = 0; i < DEPTH; i++) pop_expect(i[0], 8'(8'h60 + i), "R6 drain");
    check("R6 dropped entry absent", int'(iss_valid), 0);
    check("R6 empty", int'(empty), 1);
  endtask

  task automatic t_hold();
    bypass_en = 0; wait_ack = 0;
    enq(1, 8'h33, 1, "R9");
    step();
    enq(0, 8'h44, 1, "R9");
    check("R9 held addr", int'(iss_addr), 8'h33);
    check("R9 held kind", int'(iss_is_store), 1);
    pop_expect(1, 8'h33, "R9"); pop_expect(0, 8'h44, "R9");
  endtask

  task automatic t_wait_ack();
    bypass_en = 0; wait_ack = 1;
    enq(0, 8'h81, 1, "R7"); enq(1, 8'h82, 1, "R7");
    pop_expect(0, 8'h81, "R7");
    check("R7 blocked after issue", int'(iss_valid), 0);
    step(); step();
    check("R7 still blocked", int'(iss_valid), 0);
    ack = 1; step(); ack = 0;
    check("R7 released after ack", int'(iss_valid), 1);
    pop_expect(1, 8'h82, "R7");
    ack = 1; step(); ack = 0;
    check("R7 empty", int'(empty), 1);
  endtask

  task automatic t_stray_ack();
    bypass_en = 0; wait_ack = 1;
    ack = 1; step(); ack = 0;
    enq(1, 8'h91, 1, "R10"); enq(1, 8'h92, 1, "R10");
    pop_expect(1, 8'h91, "R10");
    check("R10 stray ack gave no credit", int'(iss_valid), 0);
    ack = 1; step(); ack = 0;
    pop_expect(1, 8'h92, "R10");
    ack = 1; step(); ack = 0;
  endtask

  task automatic t_stream();
    bypass_en = 0; wait_ack = 0;
    enq(0, 8'hA1, 1, "R8"); enq(1, 8'hA2, 1, "R8"); enq(0, 8'hA3, 1, "R8");
    pop_expect(0, 8'hA1, "R8"); pop_expect(1, 8'hA2, "R8"); pop_expect(0, 8'hA3, "R8");
    check("R8 drained back to back", int'(empty), 1);
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog all-R actual=timeout expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_strict();
    t_bypass();
    t_oldest_load();
    t_full();
    t_hold();
    t_wait_ack();
    t_stray_ack();
    t_stream();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule